// File: doc/BRIEF.md
# Multicast Packet-to-Flit Injector

This block sits between a tile component and one virtual channel of a mesh router's local port. The component hands over a whole packet in one cycle: a body, a flag saying whether it carries data, a table of recipient tile addresses and a mask of which table entries are live. The packet waits in a small request queue. Once it reaches the head of the queue, it is cut into flits and sent to the router one flit per cycle.

The routing network cannot replicate packets, so a packet with several recipients leaves as one full unicast copy per recipient. The recipient for each copy is picked round-robin from those still owed a copy. Recipients already served are recorded in a sticky mask, and the queue entry is released when the last copy has gone. Every flit carries its kind, the channel number of this instance and the destination coordinates that the router's look-ahead routing needs. A packet without data shrinks to a single flit. The router can hold the channel at any time with its stop input.

Top module: `mcinj_flit_injector`

## Requirements
- R1: `pkt_pending_o` is high exactly when the request queue holds at least one entry. A packet is queued on every cycle where `pkt_valid_i` is high and the queue is not full.
- R2: `pkt_stop_o` is high whenever the queue occupancy is at or above `AF_LVL` (default 3 of 4 entries). A `pkt_valid_i` pulse while all `DEPTH` entries are occupied is ignored and produces no flits.
- R3: Each recipient whose bit is set in the mask gets exactly one unicast copy. The entry leaves the queue after its last copy. An entry with an all-zero mask is discarded without emitting any flit.
- R4: The next recipient is the first set, unserved mask bit found by scanning upward from the previously granted index, wrapping around. This pointer persists across packets, and after reset the scan starts at index 0.
- R5: A cycle with `rtr_stop_i` high is followed by a cycle with `flit_valid_o` low. The flit sequence then resumes where it stopped, with nothing lost or repeated.
- R6: A data packet is sent as `FLITS` flits per recipient (default 4), typed head (0), then body (1), and finally tail (2). Flit k carries body bits [k*PW +: PW], so the lowest chunk goes first.
- R7: A packet with `pkt_has_data_i` low is sent as a single flit per recipient of kind head-tail (3). That flit carries the lowest body chunk.
- R8: In table mode (`ONEHOT=0`), the destination comes from the address entry at the granted index. Entry i occupies `pkt_dests_i[i*ADDR_W +: ADDR_W]`, with x in its low `X_W` bits and y in the bits above.
- R9: In index mode (`ONEHOT=1`), the granted index is itself the coordinate. Its low `X_W` bits give x, the remaining bits give y, and the address table is ignored.
- R10: Every flit carries the channel number `VC_ID` in `flit_vc_o`.
- R11: After reset, `pkt_pending_o`, `pkt_stop_o` and `flit_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid_i | input | 1 | Requester offers a packet this cycle |
| pkt_body_i | input | FLITS*PW | Packet body |
| pkt_has_data_i | input | 1 | Packet carries data (multi-flit) |
| pkt_dests_i | input | N_DEST*ADDR_W | Recipient address table |
| pkt_mask_i | input | N_DEST | Live recipients in the table |
| rtr_stop_i | input | 1 | Router on/off back-pressure for this channel |
| pkt_stop_o | output | 1 | Queue at threshold; requester must pause |
| pkt_pending_o | output | 1 | Queue not empty |
| flit_valid_o | output | 1 | Flit present on the outputs |
| flit_kind_o | output | 2 | 0 head, 1 body, 2 tail, 3 head-tail |
| flit_vc_o | output | VC_W | Channel number |
| flit_x_o | output | X_W | Destination x |
| flit_y_o | output | Y_W | Destination y |
| flit_pl_o | output | PW | Flit payload chunk |

## Verification
A packet offered at one clock edge changes `pkt_pending_o` and `pkt_stop_o` straight after that edge, so the bench reads them two time units later in the same cycle. A flit decided in one cycle appears on the outputs after the next edge. Because of this, `rtr_stop_i` as held across an edge governs the flit seen in the following cycle, and the bench pairs each observed flit with the stop value it latched half a cycle earlier. Flit contents do not depend on that timing. The bench compares them as an ordered stream against a queue of expected flits, built by replaying round-robin recipient order on every accepted packet.

// File: rtl/mcinj_pkg.sv
package mcinj_pkg;

    typedef enum logic [1:0] {
        FL_HEAD = 2'd0,
        FL_BODY = 2'd1,
        FL_TAIL = 2'd2,
        FL_SOLO = 2'd3
    } flit_kind_e;

    // Kind of the next flit from the packet's data flag and its position.
    function automatic flit_kind_e pick_kind(input logic has_data,
                                             input logic is_first,
                                             input logic is_last);
        if (!has_data)
            return FL_SOLO;
        if (is_first)
            return FL_HEAD;
        if (is_last)
            return FL_TAIL;
        return FL_BODY;
    endfunction

endpackage

// File: rtl/mcinj_req_fifo.sv
module mcinj_req_fifo #(
    parameter int W      = 8,
    parameter int DEPTH  = 4,
    parameter int AF_LVL = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         stop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign stop_o  = (cnt_q >= CW'(AF_LVL));
    assign push_ok = push_i && !full;
    assign pop_ok  = pop_i && !empty_o;
    assign data_o  = mem[rp_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= bump(wp_q);
            if (pop_ok)  rp_q <= bump(rp_q);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    a_r2_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && push_i && !pop_i) |=> full);

    a_r1_pending_from_push: assert property (@(posedge clk) disable iff (rst)
        $rose(!empty_o) |-> $past(push_i));

endmodule

// File: rtl/mcinj_rr_pick.sv
module mcinj_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    int c;

    // Scan upward from the slot after the last grant, wrapping at N.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        c       = 0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last_i) + k) % N;
            if (!any_o && req_i[c]) begin
                any_o      = 1'b1;
                grant_o[c] = 1'b1;
                idx_o      = IW'(c);
            end
        end
    end

endmodule

// File: rtl/mcinj_splitter.sv
module mcinj_splitter
    import mcinj_pkg::*;
#(
    parameter int N      = 4,
    parameter int FLITS  = 4,
    parameter int PW     = 8,
    parameter int ADDR_W = 4,
    parameter int X_W    = 2,
    parameter int ONEHOT = 0,
    parameter int VC_ID  = 1,
    parameter int VC_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    head_valid_i,
    input  logic [FLITS*PW-1:0]     head_body_i,
    input  logic                    head_has_data_i,
    input  logic [N*ADDR_W-1:0]     head_dests_i,
    input  logic [N-1:0]            head_mask_i,
    input  logic                    rtr_stop_i,
    output logic                    pop_o,
    output logic                    flit_valid_o,
    output logic [1:0]              flit_kind_o,
    output logic [VC_W-1:0]         flit_vc_o,
    output logic [X_W-1:0]          flit_x_o,
    output logic [ADDR_W-X_W-1:0]   flit_y_o,
    output logic [PW-1:0]           flit_pl_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = (FLITS > 1) ? $clog2(FLITS) : 1;

    logic [N-1:0]      served_q, pend, grant;
    logic [IW-1:0]     last_q, idx;
    logic [CW-1:0]     cnt_q;
    logic              any, is_first, is_last, rest_empty, fire, done, drop;
    logic [ADDR_W-1:0] sel_addr;
    flit_kind_e        kind;

    assign pend = head_valid_i ? (head_mask_i & ~served_q) : '0;

    mcinj_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req_i   (pend),
        .last_i  (last_q),
        .grant_o (grant),
        .idx_o   (idx),
        .any_o   (any)
    );

    generate
        if (ONEHOT != 0) begin : g_index_coord
            logic unused_dests;
            assign unused_dests = ^head_dests_i;
            assign sel_addr     = ADDR_W'(idx);
        end else begin : g_table_coord
            assign sel_addr = head_dests_i[idx*ADDR_W +: ADDR_W];
        end
    endgenerate

    assign is_first   = (cnt_q == '0);
    assign is_last    = !head_has_data_i || (cnt_q == CW'(FLITS - 1));
    assign kind       = pick_kind(head_has_data_i, is_first, is_last);
    assign rest_empty = ((pend & ~grant) == '0);
    assign fire       = any && !rtr_stop_i;
    assign done       = fire && is_last && rest_empty;
    assign drop       = head_valid_i && !any;
    assign pop_o      = done || drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            served_q <= '0;
            cnt_q    <= '0;
            last_q   <= IW'(N - 1);
        end else if (fire) begin
            if (is_last) begin
                cnt_q    <= '0;
                last_q   <= idx;
                served_q <= done ? '0 : (served_q | grant);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (drop) begin
            served_q <= '0;
            cnt_q    <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flit_valid_o <= 1'b0;
            flit_kind_o  <= '0;
            flit_vc_o    <= '0;
            flit_x_o     <= '0;
            flit_y_o     <= '0;
            flit_pl_o    <= '0;
        end else begin
            flit_valid_o <= fire;
            if (fire) begin
                flit_kind_o <= kind;
                flit_vc_o   <= VC_W'(VC_ID);
                flit_x_o    <= sel_addr[X_W-1:0];
                flit_y_o    <= sel_addr[ADDR_W-1:X_W];
                flit_pl_o   <= head_body_i[cnt_q*PW +: PW];
            end
        end
    end

    a_r5_quiet_after_stop: assert property (@(posedge clk) disable iff (rst)
        rtr_stop_i |=> !flit_valid_o);

    a_r3_served_within_mask: assert property (@(posedge clk) disable iff (rst)
        head_valid_i |-> ((served_q & ~head_mask_i) == '0));

    a_r4_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r7_count_only_with_data: assert property (@(posedge clk) disable iff (rst)
        (head_valid_i && cnt_q != '0) |-> head_has_data_i);

endmodule

// File: rtl/mcinj_flit_injector.sv
module mcinj_flit_injector #(
    parameter int VC_ID  = 1,
    parameter int VC_W   = 2,
    parameter int N_DEST = 4,
    parameter int X_W    = 2,
    parameter int Y_W    = 2,
    parameter int PW     = 8,
    parameter int FLITS  = 4,
    parameter int DEPTH  = 4,
    parameter int AF_LVL = 3,
    parameter int ONEHOT = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pkt_valid_i,
    input  logic [FLITS*PW-1:0]      pkt_body_i,
    input  logic                     pkt_has_data_i,
    input  logic [N_DEST*(X_W+Y_W)-1:0] pkt_dests_i,
    input  logic [N_DEST-1:0]        pkt_mask_i,
    input  logic                     rtr_stop_i,
    output logic                     pkt_stop_o,
    output logic                     pkt_pending_o,
    output logic                     flit_valid_o,
    output logic [1:0]               flit_kind_o,
    output logic [VC_W-1:0]          flit_vc_o,
    output logic [X_W-1:0]           flit_x_o,
    output logic [Y_W-1:0]           flit_y_o,
    output logic [PW-1:0]            flit_pl_o
);
    localparam int ADDR_W = X_W + Y_W;
    localparam int BODY_W = FLITS * PW;
    localparam int TAB_W  = N_DEST * ADDR_W;
    localparam int ENT_W  = BODY_W + 1 + TAB_W + N_DEST;

    logic [ENT_W-1:0]  ent_in, ent_out;
    logic              empty, pop;
    logic [N_DEST-1:0] head_mask;
    logic [TAB_W-1:0]  head_dests;
    logic              head_has_data;
    logic [BODY_W-1:0] head_body;

    assign ent_in = {pkt_body_i, pkt_has_data_i, pkt_dests_i, pkt_mask_i};

    mcinj_req_fifo #(.W(ENT_W), .DEPTH(DEPTH), .AF_LVL(AF_LVL)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push_i  (pkt_valid_i),
        .data_i  (ent_in),
        .pop_i   (pop),
        .data_o  (ent_out),
        .empty_o (empty),
        .stop_o  (pkt_stop_o)
    );

    assign head_mask     = ent_out[N_DEST-1:0];
    assign head_dests    = ent_out[N_DEST +: TAB_W];
    assign head_has_data = ent_out[N_DEST + TAB_W];
    assign head_body     = ent_out[ENT_W-1 -: BODY_W];
    assign pkt_pending_o = !empty;

    mcinj_splitter #(
        .N(N_DEST), .FLITS(FLITS), .PW(PW), .ADDR_W(ADDR_W), .X_W(X_W),
        .ONEHOT(ONEHOT), .VC_ID(VC_ID), .VC_W(VC_W)
    ) u_split (
        .clk             (clk),
        .rst             (rst),
        .head_valid_i    (!empty),
        .head_body_i     (head_body),
        .head_has_data_i (head_has_data),
        .head_dests_i    (head_dests),
        .head_mask_i     (head_mask),
        .rtr_stop_i      (rtr_stop_i),
        .pop_o           (pop),
        .flit_valid_o    (flit_valid_o),
        .flit_kind_o     (flit_kind_o),
        .flit_vc_o       (flit_vc_o),
        .flit_x_o        (flit_x_o),
        .flit_y_o        (flit_y_o),
        .flit_pl_o       (flit_pl_o)
    );

endmodule

// File: tb/mcinj_flit_injector_bench.sv
module mcinj_flit_injector_bench;
    localparam int VC_ID = 1;
    localparam int ND    = 4;
    localparam int PW    = 8;
    localparam int NF    = 4;
    localparam int XW    = 2;
    localparam int YW    = 2;
    localparam int AWD   = XW + YW;
    localparam int QMAX  = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              pkt_valid = 1'b0;
    logic [NF*PW-1:0]  pkt_body = '0;
    logic              pkt_hd = 1'b0;
    logic [ND*AWD-1:0] pkt_dests = '0;
    logic [ND-1:0]     pkt_mask = '0;
    logic              rtr_stop = 1'b1;

    logic          stop_o, pend_o, fv, fv2;
    logic [1:0]    kind, kind2, vc, vc2;
    logic [XW-1:0] fx, fx2;
    logic [YW-1:0] fy, fy2;
    logic [PW-1:0] pl, pl2;

    mcinj_flit_injector u_mcinj_flit_injector (
        .clk(clk), .rst(rst), .pkt_valid_i(pkt_valid), .pkt_body_i(pkt_body),
        .pkt_has_data_i(pkt_hd), .pkt_dests_i(pkt_dests), .pkt_mask_i(pkt_mask),
        .rtr_stop_i(rtr_stop), .pkt_stop_o(stop_o), .pkt_pending_o(pend_o),
        .flit_valid_o(fv), .flit_kind_o(kind), .flit_vc_o(vc),
        .flit_x_o(fx), .flit_y_o(fy), .flit_pl_o(pl)
    );

    logic unused_oh_status_a, unused_oh_status_b;
    mcinj_flit_injector #(.ONEHOT(1)) u_mcinj_flit_injector_oh (
        .clk(clk), .rst(rst), .pkt_valid_i(pkt_valid), .pkt_body_i(pkt_body),
        .pkt_has_data_i(pkt_hd), .pkt_dests_i(pkt_dests), .pkt_mask_i(pkt_mask),
        .rtr_stop_i(rtr_stop), .pkt_stop_o(unused_oh_status_a),
        .pkt_pending_o(unused_oh_status_b),
        .flit_valid_o(fv2), .flit_kind_o(kind2), .flit_vc_o(vc2),
        .flit_x_o(fx2), .flit_y_o(fy2), .flit_pl_o(pl2)
    );

    int n_chk = 0;
    int n_fail = 0;

    int exp_kind [QMAX];
    int exp_x    [QMAX];
    int exp_y    [QMAX];
    int exp_pl   [QMAX];
    int exp_idx  [QMAX];
    int wr = 0;
    int rd = 0;
    int rr_last = ND - 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected flits of one accepted packet, in round-robin recipient order.
    task automatic model_packet(input logic [NF*PW-1:0] body, input logic hd,
                                input logic [ND*AWD-1:0] dests, input logic [ND-1:0] mask);
        logic [ND-1:0] rem;
        int pick, cnt;
        rem = mask;
        while (rem != '0) begin
            pick = -1;
            for (int k = 1; k <= ND; k++) begin
                int c;
                c = (rr_last + k) % ND;
                if (pick < 0 && rem[c]) pick = c;
            end
            cnt = hd ? NF : 1;
            for (int f = 0; f < cnt; f++) begin
                exp_kind[wr] = !hd ? 3 : (f == 0) ? 0 : (f == cnt - 1) ? 2 : 1;
                exp_pl[wr]   = int'(body[f*PW +: PW]);
                exp_x[wr]    = int'(dests[pick*AWD +: XW]);
                exp_y[wr]    = int'(dests[pick*AWD + XW +: YW]);
                exp_idx[wr]  = pick;
                wr++;
            end
            rem[pick] = 1'b0;
            rr_last   = pick;
        end
    endtask

    // Presents one packet for one edge; call at posedge+2.
    task automatic offer(input logic [NF*PW-1:0] body, input logic hd,
                         input logic [ND*AWD-1:0] dests, input logic [ND-1:0] mask,
                         input bit expect_taken);
        pkt_valid = 1'b1;
        pkt_body  = body;
        pkt_hd    = hd;
        pkt_dests = dests;
        pkt_mask  = mask;
        if (expect_taken) model_packet(body, hd, dests, mask);
        @(posedge clk);
        #2;
        pkt_valid = 1'b0;
    endtask

    // Stream monitor, sampled mid-cycle.
    logic stop_seen = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (stop_seen)
                check(!fv, "R5", "flit after router stop", int'(fv), 0);
            if (fv) begin
                if (rd >= wr) begin
                    check(1'b0, "R3", "unexpected extra flit", rd, wr);
                end else begin
                    check(int'(kind) == exp_kind[rd], "R6/R7", "flit kind", int'(kind), exp_kind[rd]);
                    check(int'(pl) == exp_pl[rd], "R6", "payload chunk", int'(pl), exp_pl[rd]);
                    check(int'(fx) == exp_x[rd], "R4/R8", "dest x", int'(fx), exp_x[rd]);
                    check(int'(fy) == exp_y[rd], "R4/R8", "dest y", int'(fy), exp_y[rd]);
                    check(int'(vc) == VC_ID, "R10", "channel id", int'(vc), VC_ID);
                    check(fv2, "R9", "index-mode flit valid", int'(fv2), 1);
                    check(int'(fx2) == (exp_idx[rd] % (1 << XW)), "R9", "index-mode x",
                          int'(fx2), exp_idx[rd] % (1 << XW));
                    check(int'(fy2) == (exp_idx[rd] >> XW), "R9", "index-mode y",
                          int'(fy2), exp_idx[rd] >> XW);
                    check(kind2 == kind && pl2 == pl && vc2 == vc, "R9", "index-mode kind/payload",
                          int'(kind2), int'(kind));
                    rd++;
                end
            end
        end
        stop_seen = rtr_stop && !rst;
    end

    task automatic drain();
        rtr_stop  = 1'b0;
        pkt_valid = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            if (rd == wr && !pend_o) break;
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: got %0d flits expected %0d", rd, wr);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(posedge clk);
        #2;
        // R11: idle after reset
        check(!pend_o, "R11", "pending after reset", int'(pend_o), 0);
        check(!stop_o, "R11", "stop after reset", int'(stop_o), 0);
        check(!fv, "R11", "flit valid after reset", int'(fv), 0);

        // Fill under router stop: R1, R2
        rtr_stop = 1'b1;
        offer(32'h4433_2211, 1'b1, 16'hFA51, 4'b1111, 1'b1);
        check(pend_o, "R1", "pending after first push", int'(pend_o), 1);
        check(!stop_o, "R2", "stop at one entry", int'(stop_o), 0);
        offer(32'h0000_00C7, 1'b0, 16'h3E2D, 4'b0101, 1'b1);
        check(!stop_o, "R2", "stop at two entries", int'(stop_o), 0);
        offer(32'hDDCC_BBAA, 1'b1, 16'h9000, 4'b1000, 1'b1);
        check(stop_o, "R2", "stop at threshold", int'(stop_o), 1);
        offer(32'h0000_005E, 1'b0, 16'h0B70, 4'b0110, 1'b1);
        offer(32'hEEEE_EEEE, 1'b1, 16'hFFFF, 4'b1111, 1'b0);
        check(stop_o, "R2", "stop while full", int'(stop_o), 1);
        check(rd == 0, "R5", "no flits while stopped", rd, 0);
        drain();
        check(!pend_o, "R1", "pending after drain", int'(pend_o), 0);
        check(!stop_o, "R2", "stop after drain", int'(stop_o), 0);
        check(rd == wr, "R3", "directed flit count", rd, wr);

        // Zero-mask entry dropped between two packets: R3
        offer(32'h1234_5678, 1'b1, 16'h4321, 4'b0000, 1'b1);
        offer(32'h8765_4321, 1'b1, 16'h1357, 4'b0001, 1'b1);
        drain();
        check(rd == wr, "R3", "flits after zero-mask drop", rd, wr);

        // Constrained random traffic with random router back-pressure
        for (int i = 0; i < 300; ) begin
            rtr_stop = ($urandom() % 4) == 0;
            if (!stop_o && ($urandom() % 10) < 6) begin
                logic [NF*PW-1:0]  b;
                logic [ND*AWD-1:0] d;
                logic [ND-1:0]     m;
                logic              h;
                b = $urandom();
                d = 16'($urandom());
                m = 4'($urandom());
                h = ($urandom() % 3) != 0;
                pkt_valid = 1'b1;
                pkt_body  = b;
                pkt_hd    = h;
                pkt_dests = d;
                pkt_mask  = m;
                model_packet(b, h, d, m);
                i++;
            end else begin
                pkt_valid = 1'b0;
            end
            @(posedge clk);
            #2;
        end
        drain();
        check(rd == wr, "R3", "random flit count", rd, wr);
        check(!pend_o, "R1", "pending after random run", int'(pend_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule